// File: doc/BRIEF.md
# Machine-Cycle Status Capture and Wait-State Sequencer

This block sits next to an 8-bit processor that runs each machine cycle as a handful of clock states. In the first state the processor raises a sync marker and places a status byte on its data bus. The block captures that byte on the clock edge where sync is high. It then turns the byte into separate strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. These strobes are valid only during the data-transfer part of the cycle.

Peripheral modules are mapped into the upper part of the memory space. If a cycle is a memory access at or above a configurable base address, or if it is an interrupt-acknowledge cycle, the block pulls the processor's ready input low. Ready stays low until the addressed module returns an acknowledge. If no acknowledge comes within a parameterised number of states, the block releases ready by force and pulses a timeout flag. Downstream interrupt logic can use that flag to report a missing peripheral.

Top module: `cpu_status_wait_ctrl`

## Requirements
- R1: While reset is asserted, ready is high, all five strobes are low and timeout is low.
- R2: The status byte is captured on the rising clock edge where sync is high. Bit 0 marks interrupt acknowledge. Bit 1 is an active-low write flag. Bit 4 marks an output cycle. Bit 6 marks an input cycle. Bit 7 marks a memory read.
- R3: After a capture edge the block spends exactly one address state, or a wait period, with all strobes low. It then enters the data-transfer state, which lasts until the next sync edge.
- R4: In the data-transfer state the strobes are decoded from the captured byte as follows. mem_rd = bit7. mem_wr = !bit1 & !bit4. io_rd = bit6. io_wr = bit4 & !bit1. inta = bit0.
- R5: A memory access (bit7 set, or bit1 and bit4 both clear) whose address is at or above EXT_BASE drives ready low from the cycle after the capture edge.
- R6: An interrupt-acknowledge cycle (bit0 set) drives ready low whatever its address.
- R7: Any other cycle, including one addressed at EXT_BASE-1, keeps ready high.
- R8: While ready is low, an acknowledge sampled on an edge raises ready in the next cycle, and timeout stays low. This also holds on the last allowed state.
- R9: If no acknowledge arrives, ready stays low for exactly TMO_STATES cycles. Timeout is then high for exactly one cycle, the first cycle with ready high again.
- R10: An acknowledge while ready is high has no effect on ready or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Marks the first state of a machine cycle |
| data_i | input | 8 | Processor data bus, carrying status during sync |
| addr_i | input | 16 | Processor address bus |
| ack_i | input | 1 | Acknowledge from the addressed module |
| ready_o | output | 1 | Ready to the processor; low inserts wait states |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| timeout_o | output | 1 | One-cycle pulse on a forced release |

## Verification
A wrongly captured status byte shows up at the strobes in the first data-transfer cycle, which is two or more clocks after sync. A wrong address decode shows up one clock after sync, as ready falling when it should not or staying high when it should fall. A fault in the wait counter or the acknowledge path changes the length of the ready-low window, or makes timeout fire or fail to fire. Either error is visible within TMO_STATES+1 clocks of the capture edge.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int ST_INTA  = 0;
  localparam int ST_WR_N  = 1;
  localparam int ST_OUT   = 4;
  localparam int ST_INP   = 6;
  localparam int ST_MEMR  = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2,
    PH_XFER = 2'd3
  } phase_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic inta;
  } strobe_t;
endpackage

// File: rtl/stw_status_latch.sv
module stw_status_latch
  import stw_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] EXT_BASE = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] stat_q_o,
  output logic          need_wait_o
);
  logic [DW-1:0] stat_q, stat_d;
  logic          mem_acc;

  always_comb begin
    stat_d = stat_q;
    if (sync_i) stat_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_comb begin
    mem_acc     = data_i[ST_MEMR] | (~data_i[ST_WR_N] & ~data_i[ST_OUT]);
    need_wait_o = data_i[ST_INTA] | (mem_acc & (addr_i >= EXT_BASE));
  end

  assign stat_q_o = stat_q;

  // R2
  stat_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (stat_q == $past(data_i)));
endmodule

// File: rtl/stw_wait_seq.sv
module stw_wait_seq
  import stw_pkg::*;
#(
  parameter int TMO_STATES = 16,
  localparam int CW = $clog2(TMO_STATES + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  logic   need_wait_i,
  input  logic   ack_i,
  output phase_e phase_o,
  output logic   ready_o,
  output logic   timeout_o
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;
  logic          cnt_last;

  assign cnt_last = (cnt_q == CW'(TMO_STATES - 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tmo_d   = 1'b0;
    if (sync_i) begin
      phase_d = need_wait_i ? PH_WAIT : PH_ADDR;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_ADDR: phase_d = PH_XFER;
        PH_WAIT: begin
          if (ack_i) begin
            phase_d = PH_XFER;
          end else if (cnt_last) begin
            phase_d = PH_XFER;
            tmo_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign phase_o   = phase_q;
  assign ready_o   = (phase_q != PH_WAIT);
  assign timeout_o = tmo_q;

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TMO_STATES));
  // R9
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  // R9
  tmo_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ready_o);
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && ack_i && !sync_i) |=> (ready_o && !timeout_o));
endmodule

// File: rtl/stw_strobe_dec.sv
module stw_strobe_dec
  import stw_pkg::*;
#(
  parameter int DW = 8
) (
  input  phase_e        phase_i,
  input  logic [DW-1:0] stat_i,
  output strobe_t       strb_o
);
  logic xfer;

  assign xfer = (phase_i == PH_XFER);

  always_comb begin
    strb_o        = '0;
    strb_o.mem_rd = xfer & stat_i[ST_MEMR];
    strb_o.mem_wr = xfer & ~stat_i[ST_WR_N] & ~stat_i[ST_OUT];
    strb_o.io_rd  = xfer & stat_i[ST_INP];
    strb_o.io_wr  = xfer & stat_i[ST_OUT] & ~stat_i[ST_WR_N];
    strb_o.inta   = xfer & stat_i[ST_INTA];
  end
endmodule

// File: rtl/cpu_status_wait_ctrl.sv
module cpu_status_wait_ctrl
  import stw_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              DW         = 8,
  parameter logic [AW-1:0]   EXT_BASE   = 16'hC000,
  parameter int              TMO_STATES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ack_i,
  output logic          ready_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  output logic          inta_o,
  output logic          timeout_o
);
  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [DW-1:0] stat_q;
  logic          need_wait;
  phase_e        phase;
  strobe_t       strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  stw_status_latch #(.AW(AW), .DW(DW), .EXT_BASE(EXT_BASE)) u_latch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sync_i     (sync_i),
    .data_i     (data_i),
    .addr_i     (addr_i),
    .stat_q_o   (stat_q),
    .need_wait_o(need_wait)
  );

  stw_wait_seq #(.TMO_STATES(TMO_STATES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sync_i     (sync_i),
    .need_wait_i(need_wait),
    .ack_i      (ack_i),
    .phase_o    (phase),
    .ready_o    (ready_o),
    .timeout_o  (timeout_o)
  );

  stw_strobe_dec #(.DW(DW)) u_dec (
    .phase_i(phase),
    .stat_i (stat_q),
    .strb_o (strb)
  );

  assign mem_rd_o = strb.mem_rd;
  assign mem_wr_o = strb.mem_wr;
  assign io_rd_o  = strb.io_rd;
  assign io_wr_o  = strb.io_wr;
  assign inta_o   = strb.inta;

  // R3
  no_strobe_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ready_o |-> (strb == '0));
  // R5
  wait_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(ready_o) |-> $past(sync_i));
  // R3
  addr_state_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_i |=> (strb == '0));
endmodule

// File: tb/cpu_status_wait_ctrl_test.sv
module cpu_status_wait_ctrl_test;
  localparam int          TMO  = 16;
  localparam logic [15:0] BASE = 16'hC000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [15:0] addr_i = '0;
  logic        ack_i = 1'b0;
  logic        ready_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, inta_o, timeout_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_status_wait_ctrl #(.EXT_BASE(BASE), .TMO_STATES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .data_i(data_i), .addr_i(addr_i),
    .ack_i(ack_i), .ready_o(ready_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .inta_o(inta_o), .timeout_o(timeout_o)
  );

  function automatic logic [4:0] exp_strb(logic [7:0] s);
    return {s[7], ~s[1] & ~s[4], s[6], s[4] & ~s[1], s[0]};
  endfunction

  function automatic logic exp_wait(logic [7:0] s, logic [15:0] a);
    logic macc;
    macc = s[7] | (~s[1] & ~s[4]);
    return s[0] | (macc & (a >= BASE));
  endfunction

  function automatic logic [6:0] outs();
    return {ready_o, timeout_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, inta_o};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b ({ready,timeout,mrd,mwr,iord,iowr,inta})",
               req, act, exp);
    end
  endtask

  // ack_at: WAIT cycle index (1..TMO) in which ack is raised; 0 = never.
  task automatic run_cycle(logic [7:0] st, logic [15:0] a, int ack_at, string req);
    logic need;
    logic tmo;
    need = exp_wait(st, a);
    tmo = 1'b0;
    sync_i = 1'b1; data_i = st; addr_i = a; ack_i = 1'b0;
    @(negedge clk);
    sync_i = 1'b0; data_i = 8'($urandom);
    // R3, R5, R6, R7: first state after capture
    check({req, " R3/R5/R6/R7 post-sync"}, outs(), {~need, 6'b0});
    if (need) begin
      for (int k = 1; k <= TMO; k++) begin
        if (k == ack_at) ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        if (k == ack_at) break;
        if (k == TMO) begin tmo = 1'b1; break; end
        // R9: still waiting
        check({req, " R9 holding"}, outs(), 7'b0);
      end
    end else begin
      @(negedge clk);
    end
    // R4, R8, R9: first transfer state
    check({req, " R4/R8/R9 xfer"}, outs(), {1'b1, tmo, exp_strb(st)});
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    // R10: ack while ready high has no effect
    check({req, " R10 stray ack"}, outs(), {1'b1, 1'b0, exp_strb(st)});
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", outs(), 7'b1000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", outs(), 7'b1000000);

    // Directed corners
    run_cycle(8'h82, BASE,          1,   "R5 ext read at base");
    run_cycle(8'h82, BASE - 16'd1,  1,   "R7 read below base");
    run_cycle(8'h00, 16'hFFFF,      3,   "R5 ext write");
    run_cycle(8'h23, 16'h0000,      2,   "R6 inta low addr");
    run_cycle(8'h10, 16'hF000,      0,   "R7 io out high addr");
    run_cycle(8'h42, 16'hE000,      0,   "R7 io in");
    run_cycle(8'hA2, 16'hC100,      TMO, "R8 ack on last state");
    run_cycle(8'h82, 16'hD000,      0,   "R9 timeout");
    run_cycle(8'h23, 16'h1234,      0,   "R9 inta timeout");

    // Constrained random
    for (int i = 0; i < 80; i++) begin
      logic [7:0]  st;
      logic [15:0] a;
      int          ak;
      st = 8'($urandom);
      a  = ($urandom % 2) ? 16'($urandom) | BASE : 16'($urandom) & ~BASE;
      ak = int'($urandom % (TMO + 3));
      if (ak > TMO) ak = 0;
      run_cycle(st, a, ak, "R2/R4 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule